// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of a receive path and decides, from the first six bytes of each incoming frame, whether the frame is meant for this station. It sorts the destination into three classes: broadcast (all ones), group (first byte bit 0 set, or every frame when hash-all mode is on) and individual. A group destination is looked up in a 64-entry hash table. An individual destination is compared byte for byte against the programmed station address.

Bytes arrive one per cycle when `byteValid` is high. `frameStart` flags the first byte and `frameEnd` flags the last. The block produces a one-cycle verdict, `accept` plus `miss`, and then ignores the rest of the frame. With promiscuous mode on, every frame is accepted and `miss` still reports whether the filter would have dropped it. Frame storage and frame check sequence checking are left to neighbouring blocks.

Top module: `rx_dest_screen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `verdictValid`, `accept` and `miss` are 0.
- R2: A frame of six or more bytes gives exactly one `verdictValid` pulse. The pulse falls in the cycle after the clock edge that takes the sixth byte. Later bytes of that frame produce no further pulse and have no effect.
- R3: If `frameEnd` arrives on byte k with k < 6, the frame counts as a miss. The pulse falls in the cycle after that byte, with `miss`=1.
- R4: A destination of six 0xFF bytes is a broadcast. It misses exactly when `modeRejectBcast`=1, whatever the hash and hash-all settings.
- R5: A non-broadcast destination whose byte 0 has bit 0 set uses the hash. The CRC register starts at 0xFFFFFFFF. Each byte is shifted in LSB first: feedback = reg[0] XOR data bit, the register shifts right, and on feedback=1 it is XORed with 0xEDB88320. There is no final inversion. After six bytes the index is reg[31:26], and the frame misses when `hashTable[index]` is 0.
- R6: With `modeHashAll`=1, an individual destination (byte 0 bit 0 clear) also goes through the R5 hash lookup, and the station compare is not used.
- R7: Otherwise the destination must equal the station address. Bytes 0 and 1 are `stationHi[15:8]` and `stationHi[7:0]`. Bytes 2 to 5 are `stationLo[31:24]` down to `stationLo[7:0]`. Any differing byte is a miss.
- R8: On a verdict, `accept` = !missed OR `modePromisc`, and `miss` reports the filter result whatever the mode.
- R9: `frameStart` on any valid byte restarts collection at byte 0 and discards a partly collected frame. No verdict is produced for the discarded frame.
- R10: Outside a verdict cycle, `accept` and `miss` are 0. Cycles with `byteValid` low inside a frame do not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | A frame byte is present on `byteData` |
| byteData | input | 8 | Frame byte |
| frameStart | input | 1 | Marks the first byte of a frame |
| frameEnd | input | 1 | Marks the last byte of a frame |
| modeRejectBcast | input | 1 | Treat broadcast destinations as misses |
| modeHashAll | input | 1 | Route individual destinations through the hash |
| modePromisc | input | 1 | Accept every frame, still report miss |
| stationHi | input | 16 | Station address bytes 0 and 1 |
| stationLo | input | 32 | Station address bytes 2 to 5 |
| hashTable | input | 64 | Group hash table, bit i is index i |
| verdictValid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted (valid with strobe) |
| miss | output | 1 | Filter result was a miss (valid with strobe) |

## Verification
The bench drives several kinds of destination: matching and mismatching individual addresses (first byte and last byte wrong), broadcasts under both settings of the reject bit, and group addresses against an empty hash table and against a table holding only the computed bit. These patterns separate the three decision branches and the priority between them. Hash-all runs with a matching station address show that the hash decides, not the compare. Short frames, over-long frames, restarts in the middle of a frame and idle gaps between bytes check the pulse timing. Each cycle's outputs are compared with a behavioural model.

// File: rtl/rxfilt_pkg.sv
package rxfilt_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic             take;      // byte is part of the destination field
    logic             first;     // byte is byte 0 of a new frame
    logic [CNT_W-1:0] idx;       // position of the byte in the field
    logic             last;      // byte completes the field
    logic             shortEnd;  // frame ends before the field completes
  } strobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxfilt_control.sv
module rxfilt_control
  import rxfilt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    frameStart,
  input  logic    frameEnd,
  output strobe_t strb
);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curIdx;

  always_comb begin
    curIdx        = frameStart ? '0 : cnt;
    strb.take     = byteValid & (frameStart | active);
    strb.first    = byteValid & frameStart;
    strb.idx      = curIdx;
    strb.last     = strb.take & (curIdx == CNT_W'(ADDR_BYTES - 1));
    strb.shortEnd = strb.take & frameEnd & ~strb.last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strb.take) begin
      cnt    <= curIdx + CNT_W'(1);
      active <= ~(strb.last | strb.shortEnd);
    end
  end

endmodule

// File: rtl/rxfilt_datapath.sv
module rxfilt_datapath
  import rxfilt_pkg::*;
#(
  parameter int HASH_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [7:0]           byteData,
  input  logic                 modeRejectBcast,
  input  logic                 modeHashAll,
  input  logic                 modePromisc,
  input  logic [15:0]          stationHi,
  input  logic [31:0]          stationLo,
  input  logic [HASH_BITS-1:0] hashTable,
  output logic                 verdictValid,
  output logic                 accept,
  output logic                 miss
);

  localparam int HASH_IDX_W = $clog2(HASH_BITS);

  logic [8*ADDR_BYTES-1:0] stationAll;
  logic [7:0]              stationLane [ADDR_BYTES];

  assign stationAll = {stationHi, stationLo};

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : gLane
      assign stationLane[g] = stationAll[(ADDR_BYTES-1-g)*8 +: 8];
    end
  endgenerate

  logic        bcastAcc, uniAcc, groupAcc;
  logic [31:0] crcAcc;
  logic        bcastNext, uniNext, groupNext;
  logic [31:0] crcNext;
  logic [7:0]  stationByte;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic        hashHit;
  logic        missRaw;
  logic        decide;

  always_comb begin
    stationByte = stationLane[strb.idx];
    bcastNext   = (strb.first ? 1'b1 : bcastAcc) & (byteData == 8'hFF);
    uniNext     = (strb.first ? 1'b1 : uniAcc)   & (byteData == stationByte);
    groupNext   =  strb.first ? byteData[0] : groupAcc;
    crcNext     = crcStep(strb.first ? 32'hFFFF_FFFF : crcAcc, byteData);
    hashIdx     = crcNext[31 -: HASH_IDX_W];
    hashHit     = hashTable[hashIdx];
    if (bcastNext)                    missRaw = modeRejectBcast;
    else if (groupNext | modeHashAll) missRaw = ~hashHit;
    else                              missRaw = ~uniNext;
    decide = strb.last | strb.shortEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastAcc <= 1'b0;
      uniAcc   <= 1'b0;
      groupAcc <= 1'b0;
      crcAcc   <= '1;
    end else if (strb.take) begin
      bcastAcc <= bcastNext;
      uniAcc   <= uniNext;
      groupAcc <= groupNext;
      crcAcc   <= crcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictValid <= 1'b0;
      accept       <= 1'b0;
      miss         <= 1'b0;
    end else begin
      verdictValid <= decide;
      miss         <= decide & (strb.shortEnd | missRaw);
      accept       <= decide & (~(strb.shortEnd | missRaw) | modePromisc);
    end
  end

endmodule

// File: rtl/rx_dest_screen.sv
module rx_dest_screen
  import rxfilt_pkg::*;
#(
  parameter int HASH_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 byteValid,
  input  logic [7:0]           byteData,
  input  logic                 frameStart,
  input  logic                 frameEnd,
  input  logic                 modeRejectBcast,
  input  logic                 modeHashAll,
  input  logic                 modePromisc,
  input  logic [15:0]          stationHi,
  input  logic [31:0]          stationLo,
  input  logic [HASH_BITS-1:0] hashTable,
  output logic                 verdictValid,
  output logic                 accept,
  output logic                 miss
);

  strobe_t strb;

  rxfilt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .strb       (strb)
  );

  rxfilt_datapath #(.HASH_BITS(HASH_BITS)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .byteData        (byteData),
    .modeRejectBcast (modeRejectBcast),
    .modeHashAll     (modeHashAll),
    .modePromisc     (modePromisc),
    .stationHi       (stationHi),
    .stationLo       (stationLo),
    .hashTable       (hashTable),
    .verdictValid    (verdictValid),
    .accept          (accept),
    .miss            (miss)
  );

endmodule

// File: rtl/rx_dest_screen_chk.sv
module rx_dest_screen_chk #(
  parameter int HASH_BITS = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 byteValid,
  input logic [7:0]           byteData,
  input logic                 frameStart,
  input logic                 frameEnd,
  input logic                 modeRejectBcast,
  input logic                 modeHashAll,
  input logic                 modePromisc,
  input logic [15:0]          stationHi,
  input logic [31:0]          stationLo,
  input logic [HASH_BITS-1:0] hashTable,
  input logic                 verdictValid,
  input logic                 accept,
  input logic                 miss
);

  assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> (!accept && !miss));

  assert_hit_accepted_R8: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !miss) |-> accept);

  assert_miss_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && miss && !$past(modePromisc)) |-> !accept);

  assert_verdict_after_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $past(byteValid));

  assert_one_byte_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(byteValid && frameStart && frameEnd)) |-> (verdictValid && miss));

endmodule

bind rx_dest_screen rx_dest_screen_chk #(.HASH_BITS(HASH_BITS)) u_chk (.*);

// File: tb/rx_dest_screen_tb.sv
module rx_dest_screen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        frameStart = 1'b0;
  logic        frameEnd = 1'b0;
  logic        modeRejectBcast = 1'b0;
  logic        modeHashAll = 1'b0;
  logic        modePromisc = 1'b0;
  logic [15:0] stationHi = 16'h0211;
  logic [31:0] stationLo = 32'h2233_4455;
  logic [63:0] hashTable = 64'h0;
  logic        verdictValid, accept, miss;

  always #4 clk = ~clk;

  rx_dest_screen u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .modeRejectBcast(modeRejectBcast), .modeHashAll(modeHashAll),
    .modePromisc(modePromisc), .stationHi(stationHi), .stationLo(stationLo),
    .hashTable(hashTable), .verdictValid(verdictValid), .accept(accept), .miss(miss)
  );

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned seen[$];
  bit    mActive = 0;
  bit    live = 0;
  bit    expV = 0, expA = 0, expM = 0;
  string expTag = "R1";

  function automatic int hashIndexOf(input byte unsigned d[$]);
    int unsigned c = 32'hFFFF_FFFF;
    foreach (d[k]) begin
      for (int b = 0; b < 8; b++) begin
        bit fb = c[0] ^ d[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return int'(c >> 26);
  endfunction

  task automatic judge();
    bit isB = 1, isG, missed;
    byte unsigned st[6];
    st = '{stationHi[15:8], stationHi[7:0], stationLo[31:24],
           stationLo[23:16], stationLo[15:8], stationLo[7:0]};
    foreach (seen[k]) if (seen[k] != 8'hFF) isB = 0;
    isG = seen[0][0];
    if (isB) begin
      missed = modeRejectBcast; expTag = "R4";
    end else if (isG || modeHashAll) begin
      missed = !hashTable[hashIndexOf(seen)];
      expTag = isG ? "R5" : "R6";
    end else begin
      missed = 0;
      foreach (seen[k]) if (seen[k] != st[k]) missed = 1;
      expTag = "R7";
    end
    if (modePromisc) expTag = "R8";
    expV = 1; expM = missed; expA = !missed || modePromisc;
  endtask

  always @(posedge clk) begin
    expV = 0; expA = 0; expM = 0; expTag = "R10";
    if (!rstN) begin
      mActive = 0; seen.delete(); expTag = "R1";
    end else begin
      live = 1;
      if (byteValid) begin
        if (frameStart) begin seen.delete(); mActive = 1; end
        if (mActive) begin
          seen.push_back(byteData);
          if (seen.size() == 6) begin
            judge(); mActive = 0;
          end else if (frameEnd) begin
            expV = 1; expM = 1; expA = modePromisc; expTag = "R3"; mActive = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (verdictValid) pulses++;
    if (live) begin
      check(verdictValid == expV, expTag, "verdictValid", verdictValid, expV);
      check(accept == expA, expTag, "accept", accept, expA);
      check(miss == expM, expTag, "miss", miss, expM);
    end
    if (cycles > 20000) begin
      check(0, "R2", "watchdog expired", cycles, 20000);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  byte unsigned pat[16];

  task automatic putByte(input bit v, input byte unsigned d, input bit s, input bit e);
    @(negedge clk);
    byteValid = v; byteData = d; frameStart = s; frameEnd = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) putByte(0, 8'h00, 0, 0);
  endtask

  task automatic sendPat(input int len, input bit withEnd, input bit gaps);
    for (int i = 0; i < len; i++) begin
      putByte(1, pat[i], i == 0, withEnd && (i == len - 1));
      if (gaps) putByte(0, 8'hA5, 0, 0);
    end
    idle(3);
  endtask

  task automatic setDest(input byte unsigned a0, a1, a2, a3, a4, a5);
    pat[0] = a0; pat[1] = a1; pat[2] = a2; pat[3] = a3; pat[4] = a4; pat[5] = a5;
    for (int i = 6; i < 16; i++) pat[i] = byte'(8'h30 + i);
  endtask

  function automatic int patIndex();
    byte unsigned q[$];
    for (int i = 0; i < 6; i++) q.push_back(pat[i]);
    return hashIndexOf(q);
  endfunction

  initial begin
    int p0;
    idle(3);
    check(verdictValid == 0 && accept == 0 && miss == 0, "R1", "outputs in reset",
          {verdictValid, accept, miss}, 0);
    rstN = 1;
    idle(2);
    check(verdictValid == 0 && accept == 0 && miss == 0, "R1", "outputs after reset",
          {verdictValid, accept, miss}, 0);

    // R7: individual match, mismatch first byte, mismatch last byte
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); sendPat(8, 1, 0);
    setDest(8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); sendPat(8, 1, 0);
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h54); sendPat(8, 1, 0);
    // R10: gaps inside a frame
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); sendPat(7, 1, 1);

    // R4: broadcast, both settings, also with hash-all
    setDest(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF); sendPat(8, 1, 0);
    modeRejectBcast = 1; sendPat(8, 1, 0);
    modeHashAll = 1; hashTable = '1; sendPat(8, 1, 0);
    modeHashAll = 0; hashTable = '0; modeRejectBcast = 0;

    // R5: group address, empty table then only computed bit set
    setDest(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01); sendPat(8, 1, 0);
    hashTable = 64'h1 << patIndex(); sendPat(8, 1, 0);
    hashTable = ~(64'h1 << patIndex()); sendPat(8, 1, 0);
    hashTable = '0;

    // R6: hash-all routes a matching individual address through hash
    modeHashAll = 1;
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); sendPat(8, 1, 0);
    hashTable = 64'h1 << patIndex(); sendPat(8, 1, 0);
    modeHashAll = 0; hashTable = '0;

    // R8: promiscuous accepts a miss and still reports it
    modePromisc = 1;
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56); sendPat(8, 1, 0);
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55); sendPat(8, 1, 0);
    sendPat(3, 1, 0);
    modePromisc = 0;

    // R3: short frames
    sendPat(3, 1, 0);
    sendPat(1, 1, 0);
    sendPat(5, 1, 0);

    // R2: long frame gives exactly one pulse; frame ending on byte six
    p0 = pulses;
    sendPat(14, 1, 0);
    check(pulses - p0 == 1, "R2", "pulses for long frame", pulses - p0, 1);
    p0 = pulses;
    sendPat(6, 1, 0);
    check(pulses - p0 == 1, "R2", "pulses for six-byte frame", pulses - p0, 1);

    // R9: restart in the middle of a frame
    p0 = pulses;
    setDest(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    putByte(1, 8'h77, 1, 0);
    putByte(1, 8'h66, 0, 0);
    putByte(1, 8'h55, 0, 0);
    sendPat(8, 1, 0);
    check(pulses - p0 == 1, "R9", "pulses after restart", pulses - p0, 1);

    idle(4);
    finishRun();
  end

endmodule